// File: doc/BRIEF.md
# Hiccup Overcurrent Restart Sequencer

This block decides when a step-down converter that is stuck in a short or heavy overload should stop switching for a while and then try again. It watches three flags: one saying soft-start has finished, a current-limit comparator output, and a comparator that says the output has fallen below half of its target. The fault check is armed only once soft-start has finished. A fault is declared only when current limit and the low-output flag are true together.

When a fault is declared, the block holds the converter off for a fixed number of switching-clock ticks. The default is 8800 ticks, which is 4 ms at a 2.2 MHz switching clock. It then fires a one-cycle restart request into the soft-start logic and waits for soft-start to finish again. If the overload is still present, the same off-and-retry cycle repeats. Each fault entry also gives a one-cycle event pulse that feeds a sticky overcurrent status bit elsewhere.

The off interval is counted in ticks, not in core clocks, so it scales with the switching frequency. Dropping the enable input returns the block to idle at once and clears the interval counter.

Top module: `hiccup_seq`

## Requirements
- R1: After reset, `conv_off`, `ss_restart` and `oc_event` are all 0, and the sequencer is idle.
- R2: While soft-start has not completed, `ilim` and `vout_low` both high produce no `oc_event` and no `conv_off`. Enable high in idle moves to the soft-start phase on the next clock, and `ss_done` high in that phase arms the check on the following clock.
- R3: When the block is armed and `ilim` and `vout_low` are both high at a clock edge, `conv_off` and `oc_event` are both 1 after that edge. `oc_event` is 1 for exactly one cycle.
- R4: When armed, `ilim` alone or `vout_low` alone never starts the off interval.
- R5: `conv_off` stays high until exactly OFF_TICKS clock edges with `tick` high have been sampled in the off phase. Edges with `tick` low do not count.
- R6: At the edge that samples the last tick, `conv_off` falls and `ss_restart` is 1 for one cycle. The block then re-enters the soft-start phase, unarmed.
- R7: If the fault is still present after the restarted soft-start completes, a new off interval starts, with a new `oc_event` and the full tick count.
- R8: `enable` low at any clock edge returns the block to idle: all outputs are 0 after that edge, and the tick count is cleared, so a later fault gets a full interval.
- R9: `oc_event` and `ss_restart` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enabled; low forces idle |
| tick | input | 1 | One-cycle strobe per switching cycle |
| ss_done | input | 1 | Soft-start completed |
| ilim | input | 1 | Current-limit comparator flag |
| vout_low | input | 1 | Output below half of target |
| conv_off | output | 1 | Hold converter off (off interval) |
| ss_restart | output | 1 | One-cycle request to restart soft-start |
| oc_event | output | 1 | One-cycle overcurrent event for the sticky status bit |

## Verification
The main function is driven with directed patterns first. These are a fault during soft-start, each comparator flag on its own, a full interval with gaps between ticks, a fault that persists across restarts, and a disable in the middle of the interval followed by a new fault. Between them they separate correct arming, the AND of the two flags, counting ticks rather than core clocks, and clearing the counter on disable. A long run of seeded random enable, tick and flag patterns is then compared cycle by cycle against a behavioural model in the bench. This catches ordering slips at the phase boundaries, such as a fault and the last tick arriving close together.

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int OFF_TICKS = 8800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  logic ss_done,
  input  logic ilim,
  input  logic vout_low,
  output logic conv_off,
  output logic ss_restart,
  output logic oc_event
);

  localparam int CW = $clog2(OFF_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(OFF_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SOFT, S_RUN, S_OFF} st_t;

  st_t st;
  logic [CW-1:0] cnt;

  logic fault, last_tick;
  assign fault     = ilim && vout_low;
  assign last_tick = tick && (cnt == LAST);
  assign conv_off  = (st == S_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      oc_event   <= 1'b0;
      ss_restart <= 1'b0;
    end else if (!enable) begin
      st         <= S_IDLE;
      cnt        <= '0;
      oc_event   <= 1'b0;
      ss_restart <= 1'b0;
    end else begin
      oc_event   <= 1'b0;
      ss_restart <= 1'b0;
      unique case (st)
        S_IDLE: st <= S_SOFT;
        S_SOFT: if (ss_done) st <= S_RUN;
        S_RUN: begin
          if (fault) begin
            st       <= S_OFF;
            cnt      <= '0;
            oc_event <= 1'b1;
          end
        end
        S_OFF: begin
          if (last_tick) begin
            st         <= S_SOFT;
            cnt        <= '0;
            ss_restart <= 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r3_fault_enters_off: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == S_RUN && ilim && vout_low) |=> (conv_off && oc_event));

  a_r2_event_only_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |-> ($past(st) == S_RUN && conv_off));

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_off && enable && !tick) |=> conv_off);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  a_r6_restart_leaves_off: assert property (@(posedge clk) disable iff (!rst_n)
    ss_restart |-> (!conv_off && $past(conv_off) && st == S_SOFT));

  a_r8_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!conv_off && !ss_restart && !oc_event && cnt == '0));

  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({oc_event, ss_restart}));

endmodule

// File: tb/hiccup_seq_bench.sv
module hiccup_seq_bench;
  localparam int N = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, tick = 0, ss_done = 0, ilim = 0, vout_low = 0;
  logic conv_off, ss_restart, oc_event;

  int checks = 0, failures = 0;
  bit finished = 0;

  // behavioural model: 0 idle, 1 soft-start, 2 armed, 3 off
  int m_st = 0, m_cnt = 0;
  bit m_oc = 0, m_rs = 0;

  always #2 clk = ~clk;

  hiccup_seq #(.OFF_TICKS(N)) u_hiccup_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .ss_done(ss_done),
    .ilim(ilim), .vout_low(vout_low), .conv_off(conv_off),
    .ss_restart(ss_restart), .oc_event(oc_event));

  function automatic int nxt_st(int s, int c, bit en, bit tk, bit sd, bit fl);
    if (!en) return 0;
    case (s)
      0: return 1;
      1: return sd ? 2 : 1;
      2: return fl ? 3 : 2;
      default: return (tk && c == N - 1) ? 1 : 3;
    endcase
  endfunction

  task automatic model_update();
    int ns;
    bit fl = ilim && vout_low;
    ns = nxt_st(m_st, m_cnt, enable, tick, ss_done, fl);
    m_oc = enable && m_st == 2 && fl;
    m_rs = enable && m_st == 3 && tick && m_cnt == N - 1;
    if (!enable || ns != 3) m_cnt = 0;
    else if (m_st == 3 && tick) m_cnt = m_cnt + 1;
    m_st = ns;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit en, bit tk, bit sd, bit il, bit vl, string tag);
    enable = en; tick = tk; ss_done = sd; ilim = il; vout_low = vl;
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(tag, "conv_off", int'(conv_off), int'(m_st == 3));
    chk(tag, "oc_event", int'(oc_event), int'(m_oc));
    chk(tag, "ss_restart", int'(ss_restart), int'(m_rs));
    chk("R9", "pulse overlap", int'(oc_event && ss_restart), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int offlen, nev;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1", "conv_off", int'(conv_off), 0);
    chk("R1", "ss_restart", int'(ss_restart), 0);
    chk("R1", "oc_event", int'(oc_event), 0);
    rst_n = 1'b1;

    // R2: fault while soft-start is still running
    step(1, 1, 0, 0, 0, "R2");
    repeat (5) step(1, 1, 0, 1, 1, "R2");
    chk("R2", "conv_off unarmed", int'(conv_off), 0);
    step(1, 0, 1, 0, 0, "R2");
    // R4: each flag on its own while armed
    repeat (4) step(1, 1, 1, 1, 0, "R4");
    repeat (4) step(1, 1, 1, 0, 1, "R4");
    chk("R4", "conv_off single flag", int'(conv_off), 0);
    // R3: both flags
    step(1, 0, 1, 1, 1, "R3");
    chk("R3", "oc_event", int'(oc_event), 1);
    chk("R3", "conv_off", int'(conv_off), 1);
    // R5 / R6: count ticks with gaps
    offlen = 0;
    while (conv_off && offlen < 10 * N) begin
      step(1, 1, 0, 1, 1, "R5");
      offlen++;
      if (conv_off) step(1, 0, 0, 1, 1, "R5");
    end
    chk("R5", "ticks in off interval", offlen, N);
    chk("R6", "restart pulse", int'(ss_restart), 1);
    step(1, 1, 0, 1, 1, "R6");
    chk("R6", "restart width", int'(ss_restart), 0);
    chk("R6", "unarmed after restart", int'(conv_off), 0);
    // R7: fault persists after the retry
    nev = 0;
    step(1, 1, 1, 1, 1, "R7");
    step(1, 1, 1, 1, 1, "R7");
    nev += int'(oc_event);
    offlen = 1;
    while (conv_off && offlen < 10 * N) begin
      step(1, 1, 0, 1, 1, "R7");
      if (conv_off) offlen++;
    end
    chk("R7", "second oc_event", nev, 1);
    chk("R7", "second interval ticks", offlen, N);
    // R8: disable mid-interval, then fault again gets a full interval
    step(1, 1, 1, 1, 1, "R8");
    step(1, 1, 1, 1, 1, "R8");
    repeat (5) step(1, 1, 0, 1, 1, "R8");
    step(0, 1, 0, 1, 1, "R8");
    chk("R8", "conv_off after disable", int'(conv_off), 0);
    step(1, 0, 0, 0, 0, "R8");
    step(1, 0, 1, 0, 0, "R8");
    step(1, 0, 1, 1, 1, "R8");
    offlen = 1;
    while (conv_off && offlen < 10 * N) begin
      step(1, 1, 0, 0, 0, "R8");
      if (conv_off) offlen++;
    end
    chk("R8", "full interval after disable", offlen, N);

    // random phase against the model
    for (int i = 0; i < 20000; i++) begin
      bit en = ($urandom % 64) != 0;
      bit tk = ($urandom % 3) == 0;
      bit sd = ($urandom % 4) != 0;
      bit il = ($urandom % 2) == 0;
      bit vl = ($urandom % 3) != 0;
      step(en, tk, sd, il, vl, "R5");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule